// File: doc/BRIEF.md
# Grouped Interrupt Expander

This block gathers a large set of interrupt request lines, 12 groups of 8 by default, and reduces them to one request toward a processor core. Each request line's rising edge latches a bit in its group's flag register. Each group merges its flagged and enabled members into one group line. That line passes through a per-group acknowledge gate into a CPU-level flag register. A CPU-level enable register and a global unmask bit then decide whether the core sees a request. The request carries the winning group and member index.

The core takes a request through a valid/ready handshake. `irq_valid` holds while a flagged, enabled and unmasked request exists. An accept happens in a cycle where `irq_valid` and `irq_ready` are both high. Only an accept (or a register write) removes the request, so the core may hold `irq_ready` low for as long as it likes. The winner may still change while the core waits, if a higher-priority request arrives. An accept clears the winning member's flag and its group's CPU flag. It also sets that group's acknowledge bit, which holds the group away from the CPU until software clears it.

Software reaches every register through a single-cycle write strobe and a combinational read. A group flag write replaces the whole register. This lets software raise an unused member as a software interrupt, but it also discards any hardware flags in that group that the written value does not carry.

Top module: `grouped_irq_expander`

## Requirements
- R1: A rising edge on request line `g*8+m` sets bit m of group g's flag register (read at address 0x10+g). A line that stays high sets the bit only once, so a flag cleared by an accept stays clear while the line remains high.
- R2: A hardware edge on a member in the same cycle as a software write that clears that member's flag bit leaves the bit set.
- R3: A group raises its CPU flag bit only while some member has both its flag bit and its enable bit set (enable at address 0x00+g). The group's acknowledge bit must also be clear.
- R4: `irq_valid` is high only when some group's CPU flag bit (address 0x22) and CPU enable bit (address 0x21) are both set, that group has a pending member, and bit 0 of the control register (address 0x23, 1 = unmasked) is set.
- R5: The lowest-numbered eligible group wins. Within it, the lowest-numbered member with flag and enable set is reported on `irq_member`.
- R6: An accept clears the reported member's flag bit and the group's CPU flag bit, and sets the group's acknowledge bit (address 0x20, bit g).
- R7: While a group's acknowledge bit is set, no new request from that group reaches the core. Writing 1 to an acknowledge bit clears it, and writing 0 leaves it unchanged.
- R8: A write to a group flag register replaces its contents. An enabled member set this way acts as a software interrupt, and hardware flags that the written value omits are lost.
- R9: After reset, all enable, flag and acknowledge registers read 0 and the control register reads 0 (masked).
- R10: While `irq_valid` is high and `irq_ready` is low, with no register write, `irq_valid` stays high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 96 | Request lines, line g*8+m is member m of group g |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Combinational read data for reg_addr |
| irq_valid | output | 1 | Interrupt request to the core |
| irq_ready | input | 1 | Core accepts the request |
| irq_grp | output | 4 | Winning group index |
| irq_member | output | 3 | Winning member index within the group |

## Verification
The bench applies single isolated edges, several simultaneous edges spread over two groups and within one group, and a held-high line. These separate edge detection from level sensing and show that both priority levels pick the lowest index. Gating is then exercised layer by layer: a member enable, a CPU enable, the global unmask bit, and a set acknowledge bit. This shows that each layer stops the request on its own. Software flag writes serve both as software interrupts and as a write colliding with a hardware edge. A long pseudo-random phase mixes sparse edges, random ready and random register writes against the reference model.

// File: rtl/ixp_pkg.sv
package ixp_pkg;
  localparam int IXP_NUM_GRP = 12;
  localparam int IXP_GRP_W   = 8;
  localparam int IXP_ADDR_W  = 6;
  localparam int IXP_DATA_W  = 16;

  // register map
  localparam int IXP_EN_BASE   = 'h00;
  localparam int IXP_FLAG_BASE = 'h10;
  localparam int IXP_ACK_ADDR  = 'h20;
  localparam int IXP_CEN_ADDR  = 'h21;
  localparam int IXP_CFL_ADDR  = 'h22;
  localparam int IXP_CTRL_ADDR = 'h23;
endpackage

// File: rtl/ixp_edge_detect.sv
module ixp_edge_detect #(
  parameter int N = 96
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= din;
  end

  assign rise = din & ~prev_q;
endmodule

// File: rtl/ixp_group_stage.sv
module ixp_group_stage #(
  parameter int GRP_W = 8,
  localparam int MID_W = (GRP_W > 1) ? $clog2(GRP_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GRP_W-1:0] rise,
  input  logic             en_wr,
  input  logic             flag_wr,
  input  logic [GRP_W-1:0] wdata,
  input  logic [GRP_W-1:0] clr_mask,
  output logic [GRP_W-1:0] en_q,
  output logic [GRP_W-1:0] flag_q,
  output logic             any_pend,
  output logic [MID_W-1:0] member
);
  logic [GRP_W-1:0] flag_d;
  logic [GRP_W-1:0] pend;

  // software write, then accept clear, then hardware set (highest precedence)
  always_comb begin
    flag_d = flag_wr ? wdata : flag_q;
    flag_d = flag_d & ~clr_mask;
    flag_d = flag_d | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      if (en_wr) en_q <= wdata;
      flag_q <= flag_d;
    end
  end

  assign pend     = flag_q & en_q;
  assign any_pend = |pend;

  always_comb begin
    member = '0;
    for (int i = GRP_W - 1; i >= 0; i--) begin
      if (pend[i]) member = MID_W'(i);
    end
  end
endmodule

// File: rtl/ixp_cpu_stage.sv
module ixp_cpu_stage #(
  parameter int NUM_GRP = 12,
  localparam int GID_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_GRP-1:0] grp_any,
  input  logic [NUM_GRP-1:0] wdata,
  input  logic               ack_wr,
  input  logic               cen_wr,
  input  logic               cfl_wr,
  input  logic               ctrl_wr,
  input  logic               accept,
  input  logic [GID_W-1:0]   acc_grp,
  output logic [NUM_GRP-1:0] ack_q,
  output logic [NUM_GRP-1:0] cen_q,
  output logic [NUM_GRP-1:0] cfl_q,
  output logic               gie_q,
  output logic               win_valid,
  output logic [GID_W-1:0]   win_grp
);
  logic [NUM_GRP-1:0] acc_mask;
  logic [NUM_GRP-1:0] ack_d;
  logic [NUM_GRP-1:0] cfl_d;
  logic [NUM_GRP-1:0] cand;

  assign acc_mask = accept ? (NUM_GRP'(1) << acc_grp) : '0;

  always_comb begin
    ack_d = ack_wr ? (ack_q & ~wdata) : ack_q;
    ack_d = ack_d | acc_mask;
    cfl_d = cfl_wr ? wdata : cfl_q;
    cfl_d = cfl_d | (grp_any & ~ack_q);
    cfl_d = cfl_d & ~acc_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= '0;
      cen_q <= '0;
      cfl_q <= '0;
      gie_q <= 1'b0;
    end else begin
      ack_q <= ack_d;
      cfl_q <= cfl_d;
      if (cen_wr)  cen_q <= wdata;
      if (ctrl_wr) gie_q <= wdata[0];
    end
  end

  assign cand      = cfl_q & cen_q & grp_any;
  assign win_valid = gie_q & (|cand);

  always_comb begin
    win_grp = '0;
    for (int g = NUM_GRP - 1; g >= 0; g--) begin
      if (cand[g]) win_grp = GID_W'(g);
    end
  end
endmodule

// File: rtl/grouped_irq_expander.sv
module grouped_irq_expander
  import ixp_pkg::*;
#(
  parameter int NUM_GRP = IXP_NUM_GRP,
  parameter int GRP_W   = IXP_GRP_W,
  parameter int ADDR_W  = IXP_ADDR_W,
  parameter int DATA_W  = IXP_DATA_W,
  localparam int NUM_SRC = NUM_GRP * GRP_W,
  localparam int GID_W   = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
  localparam int MID_W   = (GRP_W > 1) ? $clog2(GRP_W) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq_valid,
  input  logic               irq_ready,
  output logic [GID_W-1:0]   irq_grp,
  output logic [MID_W-1:0]   irq_member
);
  logic [NUM_SRC-1:0] rise;
  logic [GRP_W-1:0]   grp_en_q   [NUM_GRP];
  logic [GRP_W-1:0]   grp_flag_q [NUM_GRP];
  logic [MID_W-1:0]   mem_idx    [NUM_GRP];
  logic [NUM_SRC-1:0] grp_flag_flat;
  logic [NUM_GRP-1:0] grp_any;
  logic [NUM_GRP-1:0] ack_q, cen_q, cfl_q;
  logic               gie;
  logic               accept;

  assign accept = irq_valid & irq_ready;

  ixp_edge_detect #(.N(NUM_SRC)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (irq_req),
    .rise (rise)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic             en_wr, flag_wr;
    logic [GRP_W-1:0] clr_mask;

    assign en_wr    = reg_wr && (reg_addr == ADDR_W'(IXP_EN_BASE + g));
    assign flag_wr  = reg_wr && (reg_addr == ADDR_W'(IXP_FLAG_BASE + g));
    assign clr_mask = (accept && (irq_grp == GID_W'(g))) ?
                      (GRP_W'(1) << irq_member) : '0;

    ixp_group_stage #(.GRP_W(GRP_W)) u_grp (
      .clk     (clk),
      .rst_n   (rst_n),
      .rise    (rise[g*GRP_W +: GRP_W]),
      .en_wr   (en_wr),
      .flag_wr (flag_wr),
      .wdata   (reg_wdata[GRP_W-1:0]),
      .clr_mask(clr_mask),
      .en_q    (grp_en_q[g]),
      .flag_q  (grp_flag_q[g]),
      .any_pend(grp_any[g]),
      .member  (mem_idx[g])
    );

    assign grp_flag_flat[g*GRP_W +: GRP_W] = grp_flag_q[g];
  end

  ixp_cpu_stage #(.NUM_GRP(NUM_GRP)) u_cpu (
    .clk      (clk),
    .rst_n    (rst_n),
    .grp_any  (grp_any),
    .wdata    (reg_wdata[NUM_GRP-1:0]),
    .ack_wr   (reg_wr && (reg_addr == ADDR_W'(IXP_ACK_ADDR))),
    .cen_wr   (reg_wr && (reg_addr == ADDR_W'(IXP_CEN_ADDR))),
    .cfl_wr   (reg_wr && (reg_addr == ADDR_W'(IXP_CFL_ADDR))),
    .ctrl_wr  (reg_wr && (reg_addr == ADDR_W'(IXP_CTRL_ADDR))),
    .accept   (accept),
    .acc_grp  (irq_grp),
    .ack_q    (ack_q),
    .cen_q    (cen_q),
    .cfl_q    (cfl_q),
    .gie_q    (gie),
    .win_valid(irq_valid),
    .win_grp  (irq_grp)
  );

  always_comb begin
    irq_member = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (irq_grp == GID_W'(g)) irq_member = mem_idx[g];
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (reg_addr == ADDR_W'(IXP_EN_BASE + g))   reg_rdata = DATA_W'(grp_en_q[g]);
      if (reg_addr == ADDR_W'(IXP_FLAG_BASE + g)) reg_rdata = DATA_W'(grp_flag_q[g]);
    end
    if (reg_addr == ADDR_W'(IXP_ACK_ADDR))  reg_rdata = DATA_W'(ack_q);
    if (reg_addr == ADDR_W'(IXP_CEN_ADDR))  reg_rdata = DATA_W'(cen_q);
    if (reg_addr == ADDR_W'(IXP_CFL_ADDR))  reg_rdata = DATA_W'(cfl_q);
    if (reg_addr == ADDR_W'(IXP_CTRL_ADDR)) reg_rdata = DATA_W'(gie);
  end
endmodule

// File: rtl/ixp_checker.sv
module ixp_checker
  import ixp_pkg::*;
#(
  parameter int NUM_GRP = IXP_NUM_GRP,
  parameter int GRP_W   = IXP_GRP_W,
  parameter int ADDR_W  = IXP_ADDR_W,
  parameter int DATA_W  = IXP_DATA_W,
  localparam int NUM_SRC = NUM_GRP * GRP_W,
  localparam int GID_W   = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
  localparam int MID_W   = (GRP_W > 1) ? $clog2(GRP_W) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic               irq_valid,
  input logic               irq_ready,
  input logic [GID_W-1:0]   irq_grp,
  input logic [MID_W-1:0]   irq_member,
  input logic [NUM_GRP-1:0] ack_q,
  input logic [NUM_GRP-1:0] cfl_q,
  input logic [NUM_SRC-1:0] grp_flag_flat
);
  logic cfl_write;
  assign cfl_write = reg_wr && (reg_addr == ADDR_W'(IXP_CFL_ADDR));

  assert_mask_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(IXP_CTRL_ADDR) && !reg_wdata[0]) |=> !irq_valid);

  assert_winner_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> grp_flag_flat[int'(irq_grp) * GRP_W + int'(irq_member)]);

  assert_accept_sets_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready) |=> ack_q[$past(irq_grp)]);

  assert_ack_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfl_write |=> ((cfl_q & ~$past(cfl_q) & $past(ack_q)) == '0));

  assert_hold_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ready && !reg_wr) |=> irq_valid);
endmodule

bind grouped_irq_expander ixp_checker #(
  .NUM_GRP(NUM_GRP), .GRP_W(GRP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr       (reg_wr),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .irq_valid    (irq_valid),
  .irq_ready    (irq_ready),
  .irq_grp      (irq_grp),
  .irq_member   (irq_member),
  .ack_q        (ack_q),
  .cfl_q        (cfl_q),
  .grp_flag_flat(grp_flag_flat)
);

// File: tb/grouped_irq_expander_tb.sv
module grouped_irq_expander_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 12;
  localparam int GW = 8;
  localparam int NS = NG * GW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] irq_req = '0;
  logic          reg_wr = 1'b0;
  logic [5:0]    reg_addr = '0;
  logic [15:0]   reg_wdata = '0;
  logic [15:0]   reg_rdata;
  logic          irq_valid;
  logic          irq_ready = 1'b0;
  logic [3:0]    irq_grp;
  logic [2:0]    irq_member;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  grouped_irq_expander u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_grp(irq_grp), .irq_member(irq_member)
  );

  // ---------------- reference model ----------------
  logic [7:0]    m_en [NG];
  logic [7:0]    m_fl [NG];
  logic [11:0]   m_ack, m_cen, m_cfl;
  logic          m_gie;
  logic [NS-1:0] m_prev;
  logic          e_valid;
  int            e_grp, e_mem;

  always_comb begin
    e_valid = 1'b0; e_grp = 0; e_mem = 0;
    for (int g = 0; g < NG; g++) begin
      if (!e_valid && m_gie && m_cen[g] && m_cfl[g] && ((m_fl[g] & m_en[g]) != 0)) begin
        e_valid = 1'b1; e_grp = g;
        for (int m = GW - 1; m >= 0; m--) if (m_fl[g][m] && m_en[g][m]) e_mem = m;
      end
    end
  end

  always @(posedge clk) begin
    logic acc; int ag, am;
    logic [7:0] nfl; logic [11:0] ncfl, nack;
    acc = e_valid && irq_ready; ag = e_grp; am = e_mem;
    if (!rst_n) begin
      for (int g = 0; g < NG; g++) begin m_en[g] = '0; m_fl[g] = '0; end
      m_ack = '0; m_cen = '0; m_cfl = '0; m_gie = 1'b0; m_prev = '0;
    end else begin
      ncfl = (reg_wr && reg_addr == 6'h22) ? reg_wdata[11:0] : m_cfl;
      for (int g = 0; g < NG; g++)
        if (((m_fl[g] & m_en[g]) != 0) && !m_ack[g]) ncfl[g] = 1'b1;
      if (acc) ncfl[ag] = 1'b0;
      nack = m_ack;
      if (reg_wr && reg_addr == 6'h20) nack = nack & ~reg_wdata[11:0];
      if (acc) nack[ag] = 1'b1;
      for (int g = 0; g < NG; g++) begin
        nfl = (reg_wr && reg_addr == 6'(16 + g)) ? reg_wdata[7:0] : m_fl[g];
        if (acc && ag == g) nfl[am] = 1'b0;
        for (int m = 0; m < GW; m++) if (irq_req[g*GW+m] && !m_prev[g*GW+m]) nfl[m] = 1'b1;
        m_fl[g] = nfl;
        if (reg_wr && reg_addr == 6'(g)) m_en[g] = reg_wdata[7:0];
      end
      if (reg_wr && reg_addr == 6'h21) m_cen = reg_wdata[11:0];
      if (reg_wr && reg_addr == 6'h23) m_gie = reg_wdata[0];
      m_cfl = ncfl; m_ack = nack; m_prev = irq_req;
    end
  end

  function automatic logic [15:0] m_read(input logic [5:0] a);
    m_read = '0;
    for (int g = 0; g < NG; g++) begin
      if (a == 6'(g))      m_read = {8'h00, m_en[g]};
      if (a == 6'(16 + g)) m_read = {8'h00, m_fl[g]};
    end
    if (a == 6'h20) m_read = {4'h0, m_ack};
    if (a == 6'h21) m_read = {4'h0, m_cen};
    if (a == 6'h22) m_read = {4'h0, m_cfl};
    if (a == 6'h23) m_read = {15'h0, m_gie};
  endfunction

  // per-cycle comparison against the model (R4 valid, R5 winner)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (irq_valid !== e_valid) begin
        fails++;
        $display("FAIL R4 irq_valid act=%0b exp=%0b t=%0t", irq_valid, e_valid, $time);
      end else if (e_valid && (int'(irq_grp) != e_grp || int'(irq_member) != e_mem)) begin
        fails++;
        $display("FAIL R5 winner act=%0d.%0d exp=%0d.%0d t=%0t",
                 irq_grp, irq_member, e_grp, e_mem, $time);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [5:0] a, input int exp);
    @(negedge clk); reg_addr = a; #1;
    chk(tag, int'(reg_rdata), exp);
    chk({tag, " model"}, int'(reg_rdata), int'(m_read(a)));
  endtask

  task automatic req(input string tag, input int v, input int g, input int m);
    @(negedge clk); #1;
    chk({tag, " valid"}, int'(irq_valid), v);
    if (v != 0) begin
      chk({tag, " group"}, int'(irq_grp), g);
      chk({tag, " member"}, int'(irq_member), m);
    end
  endtask

  task automatic take();
    @(negedge clk); irq_ready = 1'b1;
    @(negedge clk); irq_ready = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    // R9: reset state
    rd("R9 enable g3", 6'h03, 0);
    rd("R9 flag g3", 6'h13, 0);
    rd("R9 ack", 6'h20, 0);
    rd("R9 cpu enable", 6'h21, 0);
    rd("R9 cpu flag", 6'h22, 0);
    rd("R9 control masked", 6'h23, 0);
    req("R9 no request", 0, 0, 0);

    wr(6'h21, 16'h0FFF);
    wr(6'h23, 16'h0001);
    wr(6'h03, 16'h00FF);

    // R1/R3: single edge held high
    @(negedge clk); irq_req[29] = 1'b1;
    idle(3);
    rd("R1 flag latched", 6'h13, 'h20);
    req("R3 group to core", 1, 3, 5);
    // R6: accept
    take(); idle(2);
    rd("R6 ack set", 6'h20, 'h008);
    rd("R1 held line no reset", 6'h13, 'h00);
    rd("R6 cpu flag cleared", 6'h22, 'h000);
    // R7: ack blocks
    @(negedge clk); irq_req[26] = 1'b1;
    idle(3);
    rd("R7 flag pending", 6'h13, 'h04);
    req("R7 blocked", 0, 0, 0);
    wr(6'h20, 16'h0000); idle(2);
    req("R7 zero write no effect", 0, 0, 0);
    rd("R7 ack kept", 6'h20, 'h008);
    wr(6'h20, 16'h0008); idle(3);
    req("R7 released", 1, 3, 2);
    take();
    @(negedge clk); irq_req[29] = 1'b0; irq_req[26] = 1'b0;
    wr(6'h20, 16'h0FFF); idle(2);

    // R5: priorities across and within groups
    wr(6'h01, 16'h00FF); wr(6'h07, 16'h00FF);
    @(negedge clk); irq_req[56] = 1'b1; irq_req[14] = 1'b1; irq_req[11] = 1'b1;
    @(negedge clk); irq_req[56] = 1'b0; irq_req[14] = 1'b0; irq_req[11] = 1'b0;
    idle(2);
    req("R5 lowest group lowest member", 1, 1, 3);
    take(); idle(2);
    req("R5 next group while g1 acked", 1, 7, 0);
    take(); idle(1);
    wr(6'h20, 16'h0FFF); idle(3);
    req("R5 remaining member", 1, 1, 6);
    take(); idle(1);
    wr(6'h20, 16'h0FFF); idle(2);
    req("R6 all drained", 0, 0, 0);

    // R3: member enable gating; R4: cpu enable and unmask
    wr(6'h05, 16'h0000);
    @(negedge clk); irq_req[41] = 1'b1;
    @(negedge clk); irq_req[41] = 1'b0;
    idle(2);
    rd("R3 flag without enable", 6'h15, 'h02);
    req("R3 disabled member", 0, 0, 0);
    wr(6'h05, 16'h00FF); idle(3);
    req("R3 enabled member", 1, 5, 1);
    wr(6'h21, 16'h0FDF); idle(1);
    req("R4 cpu enable off", 0, 0, 0);
    wr(6'h21, 16'h0FFF); idle(1);
    req("R4 cpu enable on", 1, 5, 1);
    wr(6'h23, 16'h0000); idle(1);
    req("R4 masked", 0, 0, 0);
    rd("R4 control reads masked", 6'h23, 0);
    wr(6'h23, 16'h0001); idle(1);
    // R10: hold without ready
    for (int i = 0; i < 6; i++) req("R10 held", 1, 5, 1);
    take(); idle(1);
    wr(6'h20, 16'h0FFF); idle(2);

    // R8: software interrupt
    wr(6'h0B, 16'h0080); wr(6'h1B, 16'h0080); idle(3);
    req("R8 software interrupt", 1, 11, 7);
    rd("R8 flag written", 6'h1B, 'h80);
    take(); idle(2);
    rd("R8 cleared by accept", 6'h1B, 0);
    wr(6'h20, 16'h0FFF);
    // R8: flag write drops a pending hardware flag
    wr(6'h23, 16'h0000);
    @(negedge clk); irq_req[20] = 1'b1;
    @(negedge clk); irq_req[20] = 1'b0;
    idle(2);
    rd("R8 hw flag present", 6'h12, 'h10);
    wr(6'h12, 16'h0001);
    rd("R8 write replaces", 6'h12, 'h01);
    wr(6'h12, 16'h0000); wr(6'h22, 16'h0000);

    // R2: edge beats simultaneous software clear
    @(negedge clk); reg_wr = 1'b1; reg_addr = 6'h10; reg_wdata = 16'h0000; irq_req[1] = 1'b1;
    @(negedge clk); reg_wr = 1'b0; irq_req[1] = 1'b0;
    rd("R2 hardware set wins", 6'h10, 'h02);
    wr(6'h10, 16'h0000); wr(6'h22, 16'h0000);
    wr(6'h23, 16'h0001);

    // random mix, compared against the model every cycle
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      for (int w = 0; w < NS / 32; w++)
        irq_req[w*32 +: 32] = irq_req[w*32 +: 32] ^ ($urandom & $urandom & $urandom & $urandom);
      irq_ready = ($urandom % 3) == 0;
      reg_wr = ($urandom % 6) == 0;
      reg_addr = 6'($urandom % 36);
      reg_wdata = 16'($urandom);
      if (reg_addr == 6'h23) reg_wdata[0] = ($urandom % 4) != 0;
      if (reg_addr == 6'h21) reg_wdata = 16'h0FFF ^ 16'(1 << ($urandom % 12));
      if (reg_addr >= 6'h00 && reg_addr < 6'h0C) reg_wdata[7:0] = reg_wdata[7:0] | 8'hC3;
    end
    @(negedge clk); reg_wr = 1'b0; irq_ready = 1'b0;
    for (int a = 0; a < 36; a++) rd("R8 final register match", 6'(a), int'(m_read(6'(a))));
    finish_run();
  end
endmodule